// File: doc/BRIEF.md
# Raster Line Interrupt Down-Counter

This block decides when a line interrupt becomes pending. It watches the raster position, which arrives as a horizontal count and a vertical count, and counts active display lines down from a programmable 8-bit interval. Each time the interval runs out, it emits a single-clock request to set the pending flag. Holding that flag, masking it and acknowledging it are the job of a separate interrupt controller that consumes this pulse.

The decrement happens once per line, at a horizontal position that depends on the pixel width mode. The vertical count has already advanced one horizontal step earlier. Counting covers every line from 0 up to and including the first blanking line, and the last counted line depends on the height mode. On the later lines of vertical blanking, the counter is reloaded from the interval register at that same horizontal position. An alternate display mode bypasses the counter: it raises the request at one fixed raster point and ignores the interval register. Display blanking is not an input to the block, so it cannot affect counting or pulse generation.

Top module: `line_irq_counter`

## Requirements
- R1: While `rst_n` is low, `line_irq_set` is 0 and the internal counter is held at zero. Because of this, the first counted line after reset raises a request.
- R2: A line event happens only in the clock where `h_count` arrives at the line position, meaning it differs from its value in the previous clock. The line position is 0xA6 when `wide_mode`=1 and 0x86 when `wide_mode`=0. Holding `h_count` at that position for several clocks produces one event.
- R3: A line event counts only when `v_count` is no greater than the last counted line. The last counted line is 0xE0 when `tall_mode`=0 and 0xF0 when `tall_mode`=1.
- R4: If a counted line event finds the counter at zero, `line_irq_set` is 1 in the following clock, and the counter is loaded from `reload_val`.
- R5: If a counted line event finds the counter non-zero, the counter decreases by one and no request is raised.
- R6: A line event on a line beyond the last counted line reloads the counter from `reload_val` when `vblank`=1, and leaves the counter unchanged when `vblank`=0. Neither case raises a request.
- R7: With `alt_mode`=1, a request is raised only in the clock after `h_count` arrives at 0xF6 while `v_count` is 0xC0. In this mode `reload_val` has no effect and the counter is held.
- R8: `line_irq_set` is never 1 in two consecutive clocks.
- R9: A change of `reload_val` takes effect only at the next load of the counter; a count already in progress continues from its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_count | input | 9 | Current horizontal raster count |
| v_count | input | 9 | Current vertical raster count |
| tall_mode | input | 1 | 1 selects 240 active lines, 0 selects 224 |
| wide_mode | input | 1 | 1 selects 320-pixel timing, 0 selects 256 |
| reload_val | input | 8 | Line interval loaded into the counter |
| vblank | input | 1 | High during vertical blanking |
| alt_mode | input | 1 | Selects the fixed-position request mode |
| line_irq_set | output | 1 | One-clock request to set line interrupt pending |

## Verification
The properties assume that `alt_mode`, `tall_mode` and `wide_mode` change only between frames. They also assume that the raster position moves by at most one distinct value per clock, so that an arrival is seen as one clock of change. The stimulus holds the mode inputs constant across each whole frame. It walks each line through a short list of horizontal positions around the decrement and fixed-request points, and parks on each target position for extra clocks to exercise the arrival rule. `vblank` is driven from the vertical count so that it starts on the last counted line, which exercises the case where a counted line and blanking coincide.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int HW_DEF = 9;
    localparam int VW_DEF = 9;
    localparam int RW_DEF = 8;

    // What the counter does in the next clock.
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_ALT  = 2'd3
    } lirq_act_e;
endpackage

// File: rtl/lirq_hedge.sv
module lirq_hedge #(
    parameter int HW       = 9,
    parameter int H_WIDE   = 'hA6,
    parameter int H_NARROW = 'h86,
    parameter int ALT_H    = 'hF6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_count,
    input  logic          wide_mode,
    output logic          line_hit,
    output logic          alt_hit
);
    localparam logic [HW-1:0] TGT_WIDE   = HW'(H_WIDE);
    localparam logic [HW-1:0] TGT_NARROW = HW'(H_NARROW);
    localparam logic [HW-1:0] TGT_ALT    = HW'(ALT_H);

    typedef struct packed {
        logic [HW-1:0] h_prev;
    } hedge_t;

    hedge_t st_d, st_q;
    logic [HW-1:0] line_tgt;

    always_comb begin
        st_d        = st_q;
        st_d.h_prev = h_count;
        line_tgt    = wide_mode ? TGT_WIDE : TGT_NARROW;
        line_hit    = (h_count == line_tgt) && (st_q.h_prev != line_tgt);
        alt_hit     = (h_count == TGT_ALT) && (st_q.h_prev != TGT_ALT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lirq_decide.sv
module lirq_decide
    import lirq_pkg::*;
#(
    parameter int VW         = 9,
    parameter int LAST_SHORT = 'hE0,
    parameter int LAST_TALL  = 'hF0,
    parameter int ALT_LINE   = 'hC0
) (
    input  logic          line_hit,
    input  logic          alt_hit,
    input  logic [VW-1:0] v_count,
    input  logic          tall_mode,
    input  logic          vblank,
    input  logic          alt_mode,
    output lirq_act_e     act
);
    localparam logic [VW-1:0] END_SHORT = VW'(LAST_SHORT);
    localparam logic [VW-1:0] END_TALL  = VW'(LAST_TALL);
    localparam logic [VW-1:0] FIX_LINE  = VW'(ALT_LINE);

    logic [VW-1:0] last_line;

    always_comb begin
        last_line = tall_mode ? END_TALL : END_SHORT;
        act       = ACT_IDLE;
        if (alt_mode) begin
            if (alt_hit && (v_count == FIX_LINE)) act = ACT_ALT;
        end else if (line_hit) begin
            if (v_count <= last_line) act = ACT_STEP;
            else if (vblank)          act = ACT_LOAD;
        end
    end
endmodule

// File: rtl/lirq_count.sv
module lirq_count
    import lirq_pkg::*;
#(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lirq_act_e     act,
    input  logic [RW-1:0] reload_val,
    output logic [RW-1:0] cnt,
    output logic          pulse
);
    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        unique case (act)
            ACT_STEP: begin
                if (st_q.cnt == '0) begin
                    st_d.pulse = 1'b1;
                    st_d.cnt   = reload_val;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            ACT_LOAD: st_d.cnt   = reload_val;
            ACT_ALT:  st_d.pulse = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign pulse = st_q.pulse;
endmodule

// File: rtl/line_irq_counter.sv
module line_irq_counter
    import lirq_pkg::*;
#(
    parameter int HW         = HW_DEF,
    parameter int VW         = VW_DEF,
    parameter int RW         = RW_DEF,
    parameter int H_WIDE     = 'hA6,
    parameter int H_NARROW   = 'h86,
    parameter int LAST_SHORT = 'hE0,
    parameter int LAST_TALL  = 'hF0,
    parameter int ALT_LINE   = 'hC0,
    parameter int ALT_H      = 'hF6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_count,
    input  logic [VW-1:0] v_count,
    input  logic          tall_mode,
    input  logic          wide_mode,
    input  logic [RW-1:0] reload_val,
    input  logic          vblank,
    input  logic          alt_mode,
    output logic          line_irq_set
);
    logic          line_hit_w;
    logic          alt_hit_w;
    lirq_act_e     act_w;
    logic [RW-1:0] cnt_w;

    lirq_hedge #(
        .HW(HW), .H_WIDE(H_WIDE), .H_NARROW(H_NARROW), .ALT_H(ALT_H)
    ) u_hedge (
        .clk(clk), .rst_n(rst_n), .h_count(h_count), .wide_mode(wide_mode),
        .line_hit(line_hit_w), .alt_hit(alt_hit_w)
    );

    lirq_decide #(
        .VW(VW), .LAST_SHORT(LAST_SHORT), .LAST_TALL(LAST_TALL), .ALT_LINE(ALT_LINE)
    ) u_decide (
        .line_hit(line_hit_w), .alt_hit(alt_hit_w), .v_count(v_count),
        .tall_mode(tall_mode), .vblank(vblank), .alt_mode(alt_mode), .act(act_w)
    );

    lirq_count #(
        .RW(RW)
    ) u_count (
        .clk(clk), .rst_n(rst_n), .act(act_w), .reload_val(reload_val),
        .cnt(cnt_w), .pulse(line_irq_set)
    );
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
    import lirq_pkg::*;
#(
    parameter int HW         = 9,
    parameter int VW         = 9,
    parameter int RW         = 8,
    parameter int H_WIDE     = 'hA6,
    parameter int H_NARROW   = 'h86,
    parameter int LAST_SHORT = 'hE0,
    parameter int LAST_TALL  = 'hF0,
    parameter int ALT_LINE   = 'hC0,
    parameter int ALT_H      = 'hF6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] h_count,
    input logic [VW-1:0] v_count,
    input logic          tall_mode,
    input logic          wide_mode,
    input logic [RW-1:0] reload_val,
    input logic          alt_mode,
    input logic          line_irq_set,
    input lirq_act_e     act,
    input logic [RW-1:0] cnt
);
    // R8: request never lasts two clocks
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq_set |=> !line_irq_set);

    // R7: fixed-mode request only at the fixed raster point
    p_alt_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_irq_set && $past(alt_mode)) |->
            ($past(v_count) == VW'(ALT_LINE) && $past(h_count) == HW'(ALT_H)));

    // R2: counted request only at the width-dependent position
    p_hpos_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_irq_set && !$past(alt_mode)) |->
            ($past(h_count) == ($past(wide_mode) ? HW'(H_WIDE) : HW'(H_NARROW))));

    // R3: counted request only on counted lines
    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_irq_set && !$past(alt_mode)) |->
            ($past(v_count) <= ($past(tall_mode) ? VW'(LAST_TALL) : VW'(LAST_SHORT))));

    // R4: request means the counter was at zero and is now reloaded
    p_zero_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_irq_set && !$past(alt_mode)) |->
            ($past(cnt) == '0 && cnt == $past(reload_val)));

    // R5: a step on a non-zero counter decrements it
    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) == ACT_STEP && $past(cnt) != '0) |->
            (cnt == $past(cnt) - 1'b1 && !line_irq_set));

    // R7: counter held in fixed mode
    p_alt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alt_mode) |-> cnt == $past(cnt));
endmodule

bind line_irq_counter lirq_checker #(
    .HW(HW), .VW(VW), .RW(RW), .H_WIDE(H_WIDE), .H_NARROW(H_NARROW),
    .LAST_SHORT(LAST_SHORT), .LAST_TALL(LAST_TALL), .ALT_LINE(ALT_LINE), .ALT_H(ALT_H)
) u_lirq_checker (
    .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
    .tall_mode(tall_mode), .wide_mode(wide_mode), .reload_val(reload_val),
    .alt_mode(alt_mode), .line_irq_set(line_irq_set), .act(act_w), .cnt(cnt_w)
);

// File: tb/test_line_irq_counter.sv
`timescale 1ns/1ps
module test_line_irq_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] h_count = '0;
    logic [8:0] v_count = '0;
    logic       tall_mode = 1'b0;
    logic       wide_mode = 1'b0;
    logic [7:0] reload_val = '0;
    logic       vblank = 1'b0;
    logic       alt_mode = 1'b0;
    logic       line_irq_set;

    always #5 clk = ~clk;

    line_irq_counter i_line_irq_counter (
        .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
        .tall_mode(tall_mode), .wide_mode(wide_mode), .reload_val(reload_val),
        .vblank(vblank), .alt_mode(alt_mode), .line_irq_set(line_irq_set)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state, derived from the requirements
    logic [7:0] m_cnt   = '0;  // R1: zero after reset
    logic [8:0] m_hprev = '0;
    logic       exp_pulse = 1'b0;
    string      exp_tag = "R1";

    task automatic check_out();
        checks++;
        if (line_irq_set !== exp_pulse) begin
            fails++;
            $display("FAIL %s: line_irq_set=%0b expected %0b (v=%0h h=%0h)",
                     exp_tag, line_irq_set, exp_pulse, v_count, h_count);
        end
    endtask

    // Check the result of the previous step, then apply a new raster point.
    task automatic step(input logic [8:0] h, input logic [8:0] v,
                        input bit tall, input bit wide, input bit alt,
                        input logic [7:0] rv);
        logic [8:0] last;
        logic [8:0] tgt;
        bit         vb;
        @(negedge clk);
        check_out();
        last = tall ? 9'h0F0 : 9'h0E0;
        vb   = (v >= last) && (v < 9'h0FF);
        h_count = h; v_count = v; tall_mode = tall; wide_mode = wide;
        alt_mode = alt; reload_val = rv; vblank = vb;
        exp_pulse = 1'b0;
        if (alt) begin
            exp_tag = "R7";
            if (v == 9'h0C0 && h == 9'h0F6 && m_hprev != 9'h0F6) exp_pulse = 1'b1;
        end else begin
            tgt = wide ? 9'h0A6 : 9'h086;           // R2
            exp_tag = (h == m_hprev) ? "R8" : "R3";
            if (h == tgt && m_hprev != tgt) begin
                if (v <= last) begin                // R3
                    exp_tag = "R4";
                    if (m_cnt == 8'h00) begin       // R4
                        exp_pulse = 1'b1;
                        m_cnt = rv;
                    end else begin                  // R5
                        exp_tag = "R5";
                        m_cnt = m_cnt - 8'h01;
                    end
                end else if (vb) begin              // R6
                    exp_tag = "R6";
                    m_cnt = rv;
                end else begin
                    exp_tag = "R6";
                end
            end
        end
        m_hprev = h;
    endtask

    task automatic run_frame(input bit tall, input bit wide, input bit alt,
                             input logic [7:0] rv);
        logic [8:0] hl [14] = '{9'h000, 9'h085, 9'h086, 9'h086, 9'h086, 9'h087,
                                9'h0A5, 9'h0A6, 9'h0A6, 9'h0A7, 9'h0F5, 9'h0F6,
                                9'h0F6, 9'h0F7};
        for (int v = 0; v < 262; v++) begin
            for (int k = 0; k < 14; k++) begin
                // R9: interval changes part-way through the frame
                step(hl[k], 9'(v), tall, wide, alt,
                     (v < 'h40) ? rv : rv + 8'd3);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        exp_tag = "R1";
        check_out();                          // R1: low during reset
        @(negedge clk);
        rst_n = 1'b1;
        // R1: counter starts at zero, so line 0 raises a request in frame one
        run_frame(1'b0, 1'b0, 1'b0, 8'd5);
        for (int c = 0; c < 4; c++) begin
            run_frame(c[1], c[0], 1'b0, 8'd0);
            run_frame(c[1], c[0], 1'b0, 8'd1);
            run_frame(c[1], c[0], 1'b0, 8'd7);
            run_frame(c[1], c[0], 1'b0, 8'hFD);
        end
        // R7: fixed mode ignores the interval register
        run_frame(1'b0, 1'b1, 1'b1, 8'd0);
        run_frame(1'b1, 1'b0, 1'b1, 8'd9);
        // Back to counting: counter held through fixed mode
        run_frame(1'b0, 1'b1, 1'b0, 8'd2);
        @(negedge clk);
        check_out();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule